// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of several DMA channels owns the shared transfer engine next. Each channel collects a group of peripheral request lines. Every line has its own enable, and the enabled lines are combined by a logical OR into one channel request. A channel-level enable then decides whether that request may take part in arbitration at all. Each channel also carries a 2-bit software priority level.

The winner is the channel with the highest software level. If several requesting channels share that level, the lowest channel index wins. The winner is presented as a registered one-hot grant vector with a valid flag. The grant is held until the served channel pulses `item_done`, which marks the end of its current item. A newly arriving higher-priority request therefore waits at most one item. The channel count and the number of sources per channel are parameters.

Top module: `dma_req_arbiter`

## Requirements
- R1: During and directly after reset, `grant` is all zeros and `grant_valid` is low.
- R2: When no enabled channel has an enabled, active source at an arbitration point, `grant_valid` stays low and `grant` stays all zeros.
- R3: A channel requests when at least one of its sources has both its line and its enable high. Source j of channel c sits at bit c*SRC_PER_CH+j of `periph_req` and `periph_en`. A source whose enable is low has no effect on the grant.
- R4: A channel whose bit in `ch_en` is low is never granted, even if its merged request is high.
- R5: The level of channel c is `ch_prio[2c+1:2c]`, with 00 low, 01 medium, 10 high and 11 very high. Among requesting channels, one with the greatest level is granted.
- R6: Among requesting channels that share the greatest level, the one with the lowest index is granted.
- R7: Arbitration points are the rising clock edges where `grant_valid` is low, or where `item_done` is high. At such an edge, the grant takes the winner computed from the inputs present before that edge. It appears one cycle after the request.
- R8: While `grant_valid` is high and `item_done` is low, `grant` does not change, even if a higher-priority request arrives.
- R9: `grant` has at most one bit set, and `grant_valid` is high exactly when `grant` is non-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_req | input | NUM_CH*SRC_PER_CH | Peripheral request lines, grouped by channel |
| periph_en | input | NUM_CH*SRC_PER_CH | Per-source enables, same layout as periph_req |
| ch_en | input | NUM_CH | Channel enables |
| ch_prio | input | 2*NUM_CH | Software priority level, two bits per channel |
| item_done | input | 1 | The granted channel has finished its current item |
| grant | output | NUM_CH | One-hot grant vector |
| grant_valid | output | 1 | A channel is granted |

## Verification
Two events can land on the same edge: a higher-priority request can arrive while the granted channel is signalling `item_done`. The bench provokes this by holding a low-priority grant for several cycles while a very-high request is waiting. It checks that the grant does not move until `item_done`, then moves in the cycle after the done pulse to the waiting channel and not back to the old one. The stimulus table drives every arbitration point with `item_done` high, and each resulting grant is judged against an independent priority model in the bench as well as against the table's own expected vector.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

   localparam int PRIO_W    = 2;
   localparam int PRIO_LVLS = 1 << PRIO_W;

   typedef enum logic [PRIO_W-1:0] {
      PRI_LOW  = 2'b00,
      PRI_MED  = 2'b01,
      PRI_HIGH = 2'b10,
      PRI_TOP  = 2'b11
   } prio_lvl_e;

endpackage

// File: rtl/dma_src_merge.sv
module dma_src_merge #(
   parameter int NUM_CH     = 7,
   parameter int SRC_PER_CH = 3,
   localparam int SRC_W     = NUM_CH * SRC_PER_CH
) (
   input  logic [SRC_W-1:0]  src_req,
   input  logic [SRC_W-1:0]  src_en,
   input  logic [NUM_CH-1:0] ch_en,
   output logic [NUM_CH-1:0] ch_req
);

   logic [SRC_W-1:0] src_live;

   assign src_live = src_req & src_en;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic merged;
         assign merged    = |src_live[c*SRC_PER_CH +: SRC_PER_CH];
         assign ch_req[c] = merged & ch_en[c];
      end
   endgenerate

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH     = 7,
   parameter bit SCAN_STYLE = 1'b0,
   localparam int PRI_FLAT  = NUM_CH * PRIO_W
) (
   input  logic [NUM_CH-1:0]   req,
   input  logic [PRI_FLAT-1:0] prio,
   output logic [NUM_CH-1:0]   pick,
   output logic                any
);

   logic [NUM_CH-1:0] lvl_req   [PRIO_LVLS];
   logic [NUM_CH-1:0] lvl_first [PRIO_LVLS];
   logic [PRIO_LVLS-1:0] lvl_any;

   generate
      for (genvar lv = 0; lv < PRIO_LVLS; lv++) begin : g_lvl
         for (genvar c = 0; c < NUM_CH; c++) begin : g_bit
            assign lvl_req[lv][c] = req[c] &&
                                    (prio[c*PRIO_W +: PRIO_W] == PRIO_W'(lv));
         end
         assign lvl_any[lv] = |lvl_req[lv];

         if (SCAN_STYLE) begin : g_scan
            always_comb begin
               logic seen;
               seen = 1'b0;
               lvl_first[lv] = '0;
               for (int c = 0; c < NUM_CH; c++) begin
                  if (lvl_req[lv][c] && !seen) begin
                     lvl_first[lv][c] = 1'b1;
                     seen = 1'b1;
                  end
               end
            end
         end else begin : g_isolate
            assign lvl_first[lv] = lvl_req[lv] & (~lvl_req[lv] + NUM_CH'(1));
         end
      end
   endgenerate

   always_comb begin
      logic done;
      done = 1'b0;
      pick = '0;
      for (int lv = PRIO_LVLS - 1; lv >= 0; lv--) begin
         if (lvl_any[lv] && !done) begin
            pick = lvl_first[lv];
            done = 1'b1;
         end
      end
   end

   assign any = |lvl_any;

endmodule

// File: rtl/dma_grant_hold.sv
module dma_grant_hold #(
   parameter int NUM_CH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] pick,
   input  logic              pick_any,
   input  logic              item_done,
   output logic [NUM_CH-1:0] grant,
   output logic              grant_valid
);

   logic rearb;

   assign rearb = !grant_valid || item_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant       <= '0;
         grant_valid <= 1'b0;
      end else if (rearb) begin
         grant       <= pick;
         grant_valid <= pick_any;
      end
   end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
   import dma_arb_pkg::*;
#(
   parameter int NUM_CH     = 7,
   parameter int SRC_PER_CH = 3,
   parameter bit SCAN_STYLE = 1'b0,
   localparam int SRC_W     = NUM_CH * SRC_PER_CH,
   localparam int PRI_FLAT  = NUM_CH * PRIO_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SRC_W-1:0]    periph_req,
   input  logic [SRC_W-1:0]    periph_en,
   input  logic [NUM_CH-1:0]   ch_en,
   input  logic [PRI_FLAT-1:0] ch_prio,
   input  logic                item_done,
   output logic [NUM_CH-1:0]   grant,
   output logic                grant_valid
);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("dma_req_arbiter: NUM_CH must be at least 1");
      end
      if (SRC_PER_CH < 1) begin : g_bad_src
         $error("dma_req_arbiter: SRC_PER_CH must be at least 1");
      end
   endgenerate

   logic [NUM_CH-1:0] ch_req;
   logic [NUM_CH-1:0] pick;
   logic              pick_any;

   dma_src_merge #(
      .NUM_CH     (NUM_CH),
      .SRC_PER_CH (SRC_PER_CH)
   ) u_merge (
      .src_req (periph_req),
      .src_en  (periph_en),
      .ch_en   (ch_en),
      .ch_req  (ch_req)
   );

   dma_prio_pick #(
      .NUM_CH     (NUM_CH),
      .SCAN_STYLE (SCAN_STYLE)
   ) u_pick (
      .req  (ch_req),
      .prio (ch_prio),
      .pick (pick),
      .any  (pick_any)
   );

   dma_grant_hold #(
      .NUM_CH (NUM_CH)
   ) u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .pick        (pick),
      .pick_any    (pick_any),
      .item_done   (item_done),
      .grant       (grant),
      .grant_valid (grant_valid)
   );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
   parameter int NUM_CH     = 7,
   parameter int SRC_PER_CH = 3,
   localparam int SRC_W     = NUM_CH * SRC_PER_CH
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SRC_W-1:0]  periph_req,
   input logic [SRC_W-1:0]  periph_en,
   input logic              item_done,
   input logic [NUM_CH-1:0] grant,
   input logic              grant_valid
);

   // R9
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R9
   valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid == (grant != '0));

   // R8
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !item_done) |=> $stable(grant));

   // R2
   idle_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!grant_valid || item_done) && ((periph_req & periph_en) == '0))
      |=> !grant_valid);

   // R1
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reset_clear_chk: assert (grant == '0 && !grant_valid);
      end
   end

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(
   .NUM_CH     (NUM_CH),
   .SRC_PER_CH (SRC_PER_CH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .periph_req  (periph_req),
   .periph_en   (periph_en),
   .item_done   (item_done),
   .grant       (grant),
   .grant_valid (grant_valid)
);

// File: tb/dma_req_arbiter_test.sv
module dma_req_arbiter_test;

   localparam int N   = 7;
   localparam int S   = 3;
   localparam int SW  = N * S;
   localparam int NV  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] periph_req = '0;
   logic [SW-1:0] periph_en  = '0;
   logic [N-1:0]  ch_en      = '0;
   logic [2*N-1:0] ch_prio   = '0;
   logic          item_done  = 1'b0;
   logic [N-1:0]  grant;
   logic          grant_valid;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   dma_req_arbiter #(.NUM_CH(N), .SRC_PER_CH(S)) uut (
      .clk (clk), .rst_n (rst_n), .periph_req (periph_req),
      .periph_en (periph_en), .ch_en (ch_en), .ch_prio (ch_prio),
      .item_done (item_done), .grant (grant), .grant_valid (grant_valid)
   );

   // stimulus: {req, en, ch_en, prio}
   localparam logic [SW+SW+N+2*N-1:0] STIM [NV] = '{
      {21'h000040, 21'h1FFFFF, 7'h7F, 14'h0000},
      {21'h008008, 21'h1FFFFF, 7'h7F, 14'h0C04},
      {21'h102000, 21'h1FFFFF, 7'h7F, 14'h2200},
      {21'h1FFFFF, 21'h1FFFFF, 7'h7F, 14'h0000},
      {21'h1FFFFF, 21'h1FFFFF, 7'h7E, 14'h0000},
      {21'h000800, 21'h1FF7FF, 7'h7F, 14'h3FFF},
      {21'h1FFFFF, 21'h1FFFFF, 7'h7F, 14'h3FFF},
      {21'h1FFFFF, 21'h1FFFFF, 7'h7F, 14'h3AAA}
   };
   localparam logic [N-1:0] EXP [NV] = '{
      7'h04, 7'h20, 7'h10, 7'h01, 7'h02, 7'h00, 7'h01, 7'h40
   };

   function automatic logic [N-1:0] model(input logic [SW-1:0] r,
                                          input logic [SW-1:0] e,
                                          input logic [N-1:0] ce,
                                          input logic [2*N-1:0] p);
      logic [N-1:0] res = '0;
      int best = -1;
      for (int c = 0; c < N; c++) begin
         logic hit = 1'b0;
         for (int j = 0; j < S; j++) hit |= r[c*S+j] & e[c*S+j];
         if (hit && ce[c] && int'(p[2*c +: 2]) > best) begin
            best = int'(p[2*c +: 2]);
            res = '0;
            res[c] = 1'b1;
         end
      end
      return res;
   endfunction

   task automatic check(input string req, input logic [N-1:0] exp_g);
      total++;
      if (grant !== exp_g || grant_valid !== (exp_g != '0)) begin
         bad++;
         $display("FAIL %s: grant=%h valid=%b expected grant=%h valid=%b",
                  req, grant, grant_valid, exp_g, exp_g != '0);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      #2000000;
      bad++;
      total++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", '0);
      rst_n = 1'b1;
      tick();
      check("R2 idle after reset", '0);

      // table walk: item_done high so every edge is an arbitration point
      item_done = 1'b1;
      for (int k = 0; k < NV; k++) begin
         {periph_req, periph_en, ch_en, ch_prio} = STIM[k];
         tick();
         check("R3/R4/R5/R6/R7 table", EXP[k]);
         check("R5/R6 model", model(periph_req, periph_en, ch_en, ch_prio));
      end

      // R8: hold a low grant while a very high request waits
      item_done = 1'b1;
      periph_en = '1; ch_en = '1;
      periph_req = 21'h000200;          // ch3 only
      ch_prio = 14'h0000;
      tick();
      check("R7 grant ch3", 7'h08);
      item_done = 1'b0;
      periph_req = 21'h000201;          // ch0 joins
      ch_prio = 14'h0003;               // ch0 very high
      for (int i = 0; i < 3; i++) begin
         tick();
         check("R8 hold ch3", 7'h08);
      end
      // R7/R8: done pulse meets the waiting very high request
      item_done = 1'b1;
      tick();
      check("R7 move to ch0", 7'h01);
      item_done = 1'b0;
      periph_req = '0;
      tick();
      check("R8 hold with no requests", 7'h01);
      item_done = 1'b1;
      tick();
      check("R2 release to idle", '0);

      // R7: idle edge grants without item_done
      item_done = 1'b0;
      periph_req = 21'h040000;          // ch6 src0
      tick();
      check("R7 idle pick ch6", 7'h40);

      // R3: disabled source ignored at re-arbitration
      item_done = 1'b1;
      periph_req = 21'h000004;          // ch0 src2
      periph_en = 21'h1FFFFB;
      tick();
      check("R3 masked source", '0);

      // R4: disabled channel ignored
      periph_en = '1;
      ch_en = 7'h7E;
      tick();
      check("R4 masked channel", '0);

      // R1: reset mid-grant
      ch_en = '1;
      tick();
      check("R7 ch0 regrant", 7'h01);
      rst_n = 1'b0;
      #1;
      check("R1 async reset", '0);
      @(negedge clk);
      check("R1 during reset", '0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule